// File: doc/BRIEF.md
# Single-Cycle Accumulator Processor Core

This block is the decode and datapath of a small 8-bit accumulator processor. It has separate program and data memories. Each clock edge it latches one instruction byte and one immediate byte from program memory. During the following cycle it executes that pair: it puts one value on an internal data bus, computes an ALU result, forms a 16-bit data-memory address, and at the next edge writes either one register or one memory location.

The register set is the accumulator, two index registers (X and Y) and an output latch. Conditional branches replace only the low byte of the program counter. Because the instruction after a branch has already been fetched, that instruction always executes before the target.

Program ROM and data RAM are outside the block. Both are read combinationally from the addresses the block drives. RAM is written at the clock edge whenever the write strobe is high.

Top module: `acc_core`

## Requirements
- R1: The instruction byte is decoded as operation = bits 7:5, mode = bits 4:2, bus source = bits 1:0. Operation codes: 0 load, 1 AND, 2 OR, 3 XOR, 4 add, 5 subtract, 6 store, 7 conditional branch.
- R2: Bus source 0 selects the immediate byte D, 1 selects RAM read data, 2 selects AC, and 3 selects the constant 0x00.
- R3: For operations 0 to 5 the mode gives address and destination. Mode 0 is [D]→AC, 1 is [X]→AC, 2 is [Y:D]→AC, 3 is [Y:X]→AC, 4 is [D]→X, 5 is [D]→Y, 6 is [D]→OUT and 7 is [Y:X]→OUT. [Y:D] means Y×256+D.
- R4: The ALU result is: load gives the bus value, AND/OR/XOR combine AC with the bus bitwise, add gives AC+bus mod 256, and subtract gives AC−bus mod 256.
- R5: Only operation 6 raises ram_we. A store writes the bus value to the address given by its mode and changes none of AC, X, Y or OUT.
- R6: For operation 7 the mode is a condition on AC, with AC read as signed. Mode 0 and 7 mean always, 1 means greater than zero, 2 means negative, 3 means not zero, 4 means zero, 5 means not negative, and 6 means negative or zero. A branch writes no register and no RAM.
- R7: A taken branch loads the bus value into PC bits 7:0 and leaves PC bits 15:8 unchanged.
- R8: The instruction at the address following a branch executes whether or not the branch is taken (one delay slot).
- R9: When no branch is taken, PC increments by one each cycle.
- R10: Synchronous active-low reset clears PC, AC, X, Y, OUT, the instruction register and D. The first instruction after reset is therefore a load of 0x00 into AC.
- R11: The instruction register and D load from ROM[PC] at every edge. The result of the instruction at address a is visible after the second edge following the edge at which rom_addr equals a.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rom_addr | output | 16 | Program counter, the program memory address |
| rom_instr | input | 8 | Instruction byte read from program memory |
| rom_imm | input | 8 | Immediate byte read from program memory |
| ram_addr | output | 16 | Data memory address |
| ram_rdata | input | 8 | Data memory read value |
| ram_wdata | output | 8 | Data memory write value (the bus) |
| ram_we | output | 1 | Data memory write strobe |
| ac_q | output | 8 | Accumulator |
| x_q | output | 8 | X index register |
| y_q | output | 8 | Y index register |
| out_q | output | 8 | Output latch |

## Verification
Some behaviour is checked by the assertions on every cycle:
- a store leaves all four registers unchanged;
- a taken branch keeps the PC high byte and loads the bus into the low byte;
- an untaken cycle increments PC;
- an XOR into AC yields the previous AC XOR the bus;
- reset clears the visible state.

The decode table, the ALU arithmetic, the branch conditions and the delay slot can only be shown by the bench scenarios. The main scenario is a non-destructive memory test: it inverts a RAM word with XOR 0xFF, stores it, XORs it back, and then branches on not-equal. Directed rows then cover the X and Y addressing forms, the zero bus source, the remaining ALU operations, a taken sign branch and a mid-run reset.

// File: rtl/acc_pkg.sv
// Shared types for the accumulator core: instruction field encodings and
// the decoded control word. Assumes an 8-bit instruction byte.
package acc_pkg;
    localparam int IW = 8;

    typedef enum logic [2:0] {
        OP_LD  = 3'd0,
        OP_AND = 3'd1,
        OP_OR  = 3'd2,
        OP_XOR = 3'd3,
        OP_ADD = 3'd4,
        OP_SUB = 3'd5,
        OP_ST  = 3'd6,
        OP_BR  = 3'd7
    } op_e;

    typedef enum logic [1:0] {SRC_IMM, SRC_RAM, SRC_AC, SRC_ZERO} src_e;
    typedef enum logic [1:0] {DST_AC, DST_X, DST_Y, DST_OUT} dst_e;
    typedef enum logic [1:0] {ADR_D, ADR_X, ADR_YD, ADR_YX} adr_e;

    typedef struct packed {
        op_e        op;
        src_e       src;
        dst_e       dst;
        adr_e       adr;
        logic [2:0] cond;
        logic       we;
        logic       wr_reg;
        logic       br;
    } dec_t;
endpackage

// File: rtl/acc_decode.sv
// Instruction decoder: splits the instruction byte into operation, mode and
// bus source, and maps the mode onto address form and destination.
// Assumes the caller gates register writes with wr_reg.
module acc_decode
    import acc_pkg::*;
(
    input  logic [IW-1:0] ir,
    output dec_t          dec
);
    logic [2:0] mode;
    assign mode = ir[4:2];

    // Combinational field decode and mode table.
    always_comb begin
        dec.op   = op_e'(ir[7:5]);
        dec.src  = src_e'(ir[1:0]);
        dec.cond = mode;
        case (mode)
            3'd0:    begin dec.adr = ADR_D;  dec.dst = DST_AC;  end
            3'd1:    begin dec.adr = ADR_X;  dec.dst = DST_AC;  end
            3'd2:    begin dec.adr = ADR_YD; dec.dst = DST_AC;  end
            3'd3:    begin dec.adr = ADR_YX; dec.dst = DST_AC;  end
            3'd4:    begin dec.adr = ADR_D;  dec.dst = DST_X;   end
            3'd5:    begin dec.adr = ADR_D;  dec.dst = DST_Y;   end
            3'd6:    begin dec.adr = ADR_D;  dec.dst = DST_OUT; end
            default: begin dec.adr = ADR_YX; dec.dst = DST_OUT; end
        endcase
        dec.br = (dec.op == OP_BR);
        dec.we = (dec.op == OP_ST);
        if (dec.br) dec.adr = ADR_D;
        dec.wr_reg = !dec.br && !dec.we;
    end
endmodule

// File: rtl/acc_alu.sv
// ALU: combines the accumulator with the bus value. Results wrap modulo
// 2**W. Store and branch fall through to pass the bus value.
module acc_alu
    import acc_pkg::*;
#(
    parameter int W = 8
) (
    input  op_e          op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    // Select the operation result.
    always_comb begin
        case (op)
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            default: y = b;
        endcase
    end
endmodule

// File: rtl/acc_branch.sv
// Branch condition unit: evaluates the mode-selected condition on the
// accumulator, read as a signed value. Assumes en is high only for branches.
module acc_branch #(
    parameter int W = 8
) (
    input  logic         en,
    input  logic [2:0]   cond,
    input  logic [W-1:0] ac,
    output logic         take
);
    logic neg, zero, hit;
    assign neg  = ac[W-1];
    assign zero = (ac == '0);

    // Condition table indexed by the mode field.
    always_comb begin
        case (cond)
            3'd1:    hit = !neg && !zero;
            3'd2:    hit = neg;
            3'd3:    hit = !zero;
            3'd4:    hit = zero;
            3'd5:    hit = !neg;
            3'd6:    hit = neg || zero;
            default: hit = 1'b1;
        endcase
    end

    assign take = en && hit;
endmodule

// File: rtl/acc_core.sv
// Single-cycle accumulator core. Instruction and immediate are registered
// from program memory each edge and executed in the following cycle.
// Assumes combinational-read ROM and RAM, RAM written on the clock edge.
module acc_core
    import acc_pkg::*;
#(
    parameter int W    = 8,
    parameter int PC_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [PC_W-1:0] rom_addr,
    input  logic [IW-1:0]   rom_instr,
    input  logic [W-1:0]    rom_imm,
    output logic [2*W-1:0]  ram_addr,
    input  logic [W-1:0]    ram_rdata,
    output logic [W-1:0]    ram_wdata,
    output logic            ram_we,
    output logic [W-1:0]    ac_q,
    output logic [W-1:0]    x_q,
    output logic [W-1:0]    y_q,
    output logic [W-1:0]    out_q
);
    localparam int HI_W = PC_W - W;

    logic [IW-1:0]   ir;
    logic [W-1:0]    d;
    logic [PC_W-1:0] pc;
    logic [W-1:0]    bus;
    logic [W-1:0]    alu_y;
    logic            take;
    dec_t            dec;

    acc_decode u_dec (.ir(ir), .dec(dec));

    acc_alu #(.W(W)) u_alu (.op(dec.op), .a(ac_q), .b(bus), .y(alu_y));

    acc_branch #(.W(W)) u_br (.en(dec.br), .cond(dec.cond), .ac(ac_q), .take(take));

    // Bus source multiplexer.
    always_comb begin
        case (dec.src)
            SRC_IMM: bus = d;
            SRC_RAM: bus = ram_rdata;
            SRC_AC:  bus = ac_q;
            default: bus = '0;
        endcase
    end

    // Data memory address formation.
    always_comb begin
        case (dec.adr)
            ADR_X:   ram_addr = {{W{1'b0}}, x_q};
            ADR_YD:  ram_addr = {y_q, d};
            ADR_YX:  ram_addr = {y_q, x_q};
            default: ram_addr = {{W{1'b0}}, d};
        endcase
    end

    assign ram_we    = dec.we;
    assign ram_wdata = bus;
    assign rom_addr  = pc;

    // Fetch registers and program counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir <= '0;
            d  <= '0;
            pc <= '0;
        end else begin
            ir <= rom_instr;
            d  <= rom_imm;
            if (take) pc <= {pc[PC_W-1:PC_W-HI_W], bus};
            else      pc <= pc + PC_W'(1);
        end
    end

    // Architectural register writeback.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ac_q  <= '0;
            x_q   <= '0;
            y_q   <= '0;
            out_q <= '0;
        end else if (dec.wr_reg) begin
            case (dec.dst)
                DST_AC:  ac_q  <= alu_y;
                DST_X:   x_q   <= alu_y;
                DST_Y:   y_q   <= alu_y;
                default: out_q <= alu_y;
            endcase
        end
    end
endmodule

// File: rtl/acc_core_chk.sv
// Assertion checker for acc_core, attached by bind. Observes ports plus the
// internal bus, branch decision and decoded operation and destination.
module acc_core_chk #(
    parameter int W    = 8,
    parameter int PC_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PC_W-1:0] rom_addr,
    input logic            ram_we,
    input logic [W-1:0]    ac_q,
    input logic [W-1:0]    x_q,
    input logic [W-1:0]    y_q,
    input logic [W-1:0]    out_q,
    input logic [W-1:0]    bus,
    input logic            take,
    input logic [2:0]      op,
    input logic [1:0]      dst
);
    // R5: a store changes no register
    a_r5_store_keeps_regs: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> ($stable(ac_q) && $stable(x_q) && $stable(y_q) && $stable(out_q)));

    // R6: a branch never writes RAM
    a_r6_branch_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> !ram_we);

    // R7: taken branch keeps the high byte and loads the bus into the low byte
    a_r7_branch_target: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (rom_addr[PC_W-1:W] == $past(rom_addr[PC_W-1:W]) &&
                  rom_addr[W-1:0] == $past(bus)));

    // R9: sequential flow increments PC
    a_r9_pc_increment: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> rom_addr == $past(rom_addr) + PC_W'(1));

    // R4: XOR into AC combines previous AC with the bus
    a_r4_xor_ac: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd3 && dst == 2'd0) |=> ac_q == $past(ac_q ^ bus));

    // R10: reset clears visible state
    a_r10_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (ac_q == '0 && x_q == '0 && y_q == '0 && out_q == '0 && rom_addr == '0));
endmodule

bind acc_core acc_core_chk #(.W(W), .PC_W(PC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rom_addr(rom_addr), .ram_we(ram_we),
    .ac_q(ac_q), .x_q(x_q), .y_q(y_q), .out_q(out_q),
    .bus(bus), .take(take), .op(dec.op), .dst(dec.dst)
);

// File: tb/acc_core_bench.sv
`timescale 1ns/1ps
// Bench for acc_core: ROM and RAM models, a table of executed program rows
// with expected register and PC values, then directed RAM and reset checks.
module acc_core_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] rom_addr, ram_addr;
    logic [7:0]  rom_instr, rom_imm, ram_rdata, ram_wdata;
    logic        ram_we;
    logic [7:0]  ac_q, x_q, y_q, out_q;
    int          checks = 0;
    int          errors = 0;

    logic [15:0] rom [0:255];
    logic [7:0]  ram [0:4095];

    always #5 clk = ~clk;

    acc_core u_acc_core (
        .clk(clk), .rst_n(rst_n), .rom_addr(rom_addr), .rom_instr(rom_instr),
        .rom_imm(rom_imm), .ram_addr(ram_addr), .ram_rdata(ram_rdata),
        .ram_wdata(ram_wdata), .ram_we(ram_we), .ac_q(ac_q), .x_q(x_q),
        .y_q(y_q), .out_q(out_q)
    );

    assign rom_instr = rom[rom_addr[7:0]][15:8];
    assign rom_imm   = rom[rom_addr[7:0]][7:0];
    assign ram_rdata = ram[ram_addr[11:0]];

    always @(posedge clk) if (ram_we) ram[ram_addr[11:0]] <= ram_wdata;

    typedef struct packed {
        logic [7:0] addr, ins, imm, ac, x, y, out, pc, rq;
    } row_t;

    localparam int N = 28;
    // Row fields: addr, instr, imm, AC, X, Y, OUT, PC after, requirement.
    // Instruction fields per R1: op[7:5] mode[4:2] src[1:0].
    localparam row_t TBL [N] = '{
        '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h02, 8'd11}, // R11 R1 ld 0
        '{8'h01, 8'h18, 8'h80, 8'h00, 8'h00, 8'h00, 8'h80, 8'h03, 8'd3},  // R3 ld ->OUT
        '{8'h02, 8'h18, 8'hC0, 8'h00, 8'h00, 8'h00, 8'hC0, 8'h04, 8'd3},  // R3
        '{8'h03, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'hC0, 8'h05, 8'd4},  // R4 ld
        '{8'h04, 8'h14, 8'h01, 8'h01, 8'h00, 8'h01, 8'hC0, 8'h06, 8'd3},  // R3 ->Y
        '{8'h05, 8'hC2, 8'h01, 8'h01, 8'h00, 8'h01, 8'hC0, 8'h07, 8'd5},  // R5 st [1]
        '{8'h06, 8'h00, 8'hFF, 8'hFF, 8'h00, 8'h01, 8'hC0, 8'h08, 8'd4},  // R4
        '{8'h07, 8'h69, 8'h00, 8'hA5, 8'h00, 8'h01, 8'hC0, 8'h09, 8'd4},  // R4 xor [Y:0]
        '{8'h08, 8'hCA, 8'h00, 8'hA5, 8'h00, 8'h01, 8'hC0, 8'h0A, 8'd5},  // R5 st [Y:0]
        '{8'h09, 8'hC2, 8'h00, 8'hA5, 8'h00, 8'h01, 8'hC0, 8'h0B, 8'd5},  // R5 st [0]
        '{8'h0A, 8'h69, 8'h00, 8'h00, 8'h00, 8'h01, 8'hC0, 8'h0C, 8'd4},  // R4 xor back
        '{8'h0B, 8'hEC, 8'h0A, 8'h00, 8'h00, 8'h01, 8'hC0, 8'h0D, 8'd9},  // R9 bne untaken
        '{8'h0C, 8'h00, 8'h33, 8'h33, 8'h00, 8'h01, 8'hC0, 8'h0E, 8'd8},  // R8 slot
        '{8'h0D, 8'hEC, 8'h10, 8'h33, 8'h00, 8'h01, 8'hC0, 8'h10, 8'd7},  // R7 bne taken
        '{8'h0E, 8'h18, 8'h44, 8'h33, 8'h00, 8'h01, 8'h44, 8'h11, 8'd8},  // R8 slot runs
        '{8'h10, 8'h00, 8'h07, 8'h07, 8'h00, 8'h01, 8'h44, 8'h12, 8'd7},  // R7 target
        '{8'h11, 8'hDA, 8'h02, 8'h07, 8'h00, 8'h01, 8'h44, 8'h13, 8'd5},  // R5 st mode 6
        '{8'h12, 8'h80, 8'h03, 8'h0A, 8'h00, 8'h01, 8'h44, 8'h14, 8'd4},  // R4 add
        '{8'h13, 8'hA0, 8'h0B, 8'hFF, 8'h00, 8'h01, 8'h44, 8'h15, 8'd4},  // R4 sub wrap
        '{8'h14, 8'h20, 8'h0F, 8'h0F, 8'h00, 8'h01, 8'h44, 8'h16, 8'd4},  // R4 and
        '{8'h15, 8'h40, 8'h30, 8'h3F, 8'h00, 8'h01, 8'h44, 8'h17, 8'd4},  // R4 or
        '{8'h16, 8'h10, 8'h05, 8'h3F, 8'h05, 8'h01, 8'h44, 8'h18, 8'd3},  // R3 ->X
        '{8'h17, 8'h05, 8'h00, 8'h77, 8'h05, 8'h01, 8'h44, 8'h19, 8'd2},  // R2 ld [X] RAM
        '{8'h18, 8'h03, 8'h00, 8'h00, 8'h05, 8'h01, 8'h44, 8'h1A, 8'd2},  // R2 zero source
        '{8'h19, 8'h00, 8'h80, 8'h80, 8'h05, 8'h01, 8'h44, 8'h1B, 8'd4},  // R4
        '{8'h1A, 8'hE8, 8'h40, 8'h80, 8'h05, 8'h01, 8'h44, 8'h40, 8'd6},  // R6 branch neg
        '{8'h1B, 8'h00, 8'h01, 8'h01, 8'h05, 8'h01, 8'h44, 8'h41, 8'd8},  // R8 slot
        '{8'h40, 8'h00, 8'h09, 8'h09, 8'h05, 8'h01, 8'h44, 8'h42, 8'd6}   // R6 target
    };

    task automatic chk(input int rq, input string what, input logic [15:0] act,
                       input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 256; i++) rom[i] = 16'h0000;
        for (int i = 0; i < N; i++) rom[TBL[i].addr] = {TBL[i].ins, TBL[i].imm};
        rom[8'h0F] = 16'h00EE;   // skipped by the taken branch (R7)
        for (int i = 0; i < 4096; i++) ram[i] = 8'h00;
        ram[12'h100] = 8'h5A;
        ram[12'h005] = 8'h77;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 reset state
        chk(10, "reset AC", {8'h00, ac_q}, 16'h0000);
        chk(10, "reset PC", rom_addr, 16'h0000);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        // R11 first edge runs the cleared instruction and fetches ROM[0]
        chk(11, "PC after first edge", rom_addr, 16'h0001);

        for (int i = 0; i < N; i++) begin
            chk(TBL[i].rq, "write strobe", {15'h0, ram_we},
                {15'h0, TBL[i].ins[7:5] == 3'd6});
            @(posedge clk);
            @(negedge clk);
            chk(TBL[i].rq, "AC", {8'h00, ac_q}, {8'h00, TBL[i].ac});
            chk(TBL[i].rq, "X", {8'h00, x_q}, {8'h00, TBL[i].x});
            chk(TBL[i].rq, "Y", {8'h00, y_q}, {8'h00, TBL[i].y});
            chk(TBL[i].rq, "OUT", {8'h00, out_q}, {8'h00, TBL[i].out});
            chk(TBL[i].rq, "PC", rom_addr, {8'h00, TBL[i].pc});
        end

        // R5 stored values in RAM
        chk(5, "RAM[001]", {8'h00, ram[12'h001]}, 16'h0001);
        chk(5, "RAM[100]", {8'h00, ram[12'h100]}, 16'h00A5);
        chk(5, "RAM[000]", {8'h00, ram[12'h000]}, 16'h00A5);
        chk(5, "RAM[002]", {8'h00, ram[12'h002]}, 16'h0007);

        // R10 mid-run reset clears every register
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(10, "mid reset AC", {8'h00, ac_q}, 16'h0000);
        chk(10, "mid reset X", {8'h00, x_q}, 16'h0000);
        chk(10, "mid reset Y", {8'h00, y_q}, 16'h0000);
        chk(10, "mid reset OUT", {8'h00, out_q}, 16'h0000);
        chk(10, "mid reset PC", rom_addr, 16'h0000);
        chk(10, "mid reset strobe", {15'h0, ram_we}, 16'h0000);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(10, "post reset AC", {8'h00, ac_q}, 16'h0000);
        chk(10, "post reset PC", rom_addr, 16'h0001);
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        chk(3, "rerun OUT", {8'h00, out_q}, 16'h0080);

        finish_run();
    end
endmodule